// File: doc/BRIEF.md
# SPI Transmit Queue with Single-Entry Bypass

This block buffers transmit words between a host-side push port and an SPI shift register. The host, or a DMA engine, pushes 8-bit or 16-bit words. The shifter takes the oldest word when it starts a transfer. The block reports how many words are waiting and which slot goes out next. It also drives a level request flag that an interrupt or DMA controller can use to refill the queue. A flush input empties the queue in one cycle.

A bypass input turns the queue into a single-entry double buffer. Occupancy and the request flag then behave as for a one-word queue, and the slot index and per-slot readback read as zero. Change the bypass input only while the queue is empty, for example right after a flush.

Three states track occupancy. OCC_EMPTY moves to OCC_PART on an accepted push, or straight to OCC_FULL when the capacity is one. OCC_PART moves to OCC_FULL when a push fills the last slot, and back to OCC_EMPTY when a pop removes the last word. OCC_FULL moves to OCC_PART on a pop, or to OCC_EMPTY when the capacity is one. A flush sends every state to OCC_EMPTY.

The request flag has two states. FL_REQ drives the flag high. FL_QUIET drives it low. A flush, or an update that leaves the queue below capacity, moves the flag to FL_REQ. A write of 1 to clear the flag, or a write-complete strobe while the queue is full, moves it to FL_QUIET.

Top module: `spi_txq`

## Requirements
- R1: After reset the count is 0, the next slot index is 0, the request flag is 1 and the underflow flag is 0.
- R2: Accepted pushes leave in first-in first-out order. `pop_data` shows the oldest word. Each accepted push adds 1 to the count and each accepted pop subtracts 1. The capacity is 4 words when bypass is low.
- R3: A push while the queue is full is dropped. The count, the stored words and the slot index stay unchanged, and no flag is raised.
- R4: On each accepted pop the next slot index advances by one, wrapping from 3 to 0.
- R5: A push and a pop in the same cycle, with the queue neither empty nor full, are both accepted and leave the count unchanged.
- R6: When `push_byte` is 1, only `push_data[7:0]` is stored and the upper bits are 0. When `push_byte` is 0, all 16 bits are stored.
- R7: The request flag is 1 after any cycle that leaves the queue below capacity. It stays 1 when the queue becomes full. It drops to 0 after a `wr_done` strobe arrives while the queue is full.
- R8: A `fill_clr` pulse forces the request flag to 0 in the next cycle. The flag returns to 1 one cycle later if the queue is not full.
- R9: `flush` clears the count and both slot pointers and sets the request flag, all in the next cycle. It overrides a push or pop in the same cycle.
- R10: A pop request on an empty queue is ignored, with `pop_ack` at 0 and the count left at 0. It sets the underflow flag, which `ufl_clr` clears. A new underflow wins over a clear in the same cycle.
- R11: With bypass at 1, the capacity is one word: a second push is dropped, `wr_done` clears the request flag after one push, and `next_ptr` and `entry_data` read 0.
- R12: With bypass at 0, `entry_data` shows the word held in slot `entry_idx`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bypass | input | 1 | Single-entry double-buffer mode |
| flush | input | 1 | Empty the queue |
| push_valid | input | 1 | Push request from host or DMA |
| push_byte | input | 1 | 1: 8-bit push, 0: 16-bit push |
| push_data | input | 16 | Word to push |
| wr_done | input | 1 | Write-complete strobe from DMA |
| fill_clr | input | 1 | Write-1 clear of the request flag |
| ufl_clr | input | 1 | Write-1 clear of the underflow flag |
| pop_req | input | 1 | Shifter asks for the next word |
| pop_ack | output | 1 | Pop accepted this cycle |
| pop_data | output | 16 | Oldest queued word |
| count | output | 3 | Valid-entry count |
| next_ptr | output | 2 | Slot index of the next word to leave |
| fill_flag | output | 1 | Level request for refill |
| underflow | output | 1 | Pop-on-empty sticky flag |
| entry_idx | input | 2 | Slot readback select |
| entry_data | output | 16 | Slot readback data |

## Verification
A wrong count or state register shows up within one cycle. It appears at `count` and `fill_flag`, or as a dropped or duplicated word at `pop_data`. A pointer that skips or fails to wrap shows at `next_ptr` on the cycle after the pop. It also shows on the next later pop, when `pop_data` presents the wrong word. A request flag that misses a set or clear condition is visible at `fill_flag` one cycle after the triggering strobe. The bench samples each of these outputs right after the edge that updates them.

// File: rtl/spi_txq_pkg.sv
package spi_txq_pkg;
    typedef enum logic [1:0] {
        OCC_EMPTY = 2'd0,
        OCC_PART  = 2'd1,
        OCC_FULL  = 2'd2
    } occ_state_t;

    typedef enum logic {
        FL_QUIET = 1'b0,
        FL_REQ   = 1'b1
    } fill_state_t;
endpackage

// File: rtl/spi_txq_store.sv
module spi_txq_store #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_ptr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [PTR_W-1:0]  rd_ptr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [PTR_W-1:0]  peek_idx,
    output logic [DATA_W-1:0] peek_data
);
    logic [DATA_W-1:0] slot_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
            end else if (wr_en && (wr_ptr == PTR_W'(g))) begin
                slot_q[g] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_data   = slot_q[rd_ptr];
        peek_data = slot_q[peek_idx];
    end
endmodule

// File: rtl/spi_txq_ctrl.sv
module spi_txq_ctrl
    import spi_txq_pkg::*;
#(
    parameter int DEPTH  = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bypass,
    input  logic             flush,
    input  logic             push_valid,
    input  logic             pop_req,
    output logic             push_acc,
    output logic             pop_acc,
    output logic             ufl_evt,
    output logic             full_nxt,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [CNT_W-1:0] count
);
    localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);

    occ_state_t       state_q, state_nxt;
    logic [CNT_W-1:0] cap;
    logic [CNT_W-1:0] count_nxt;
    logic [PTR_W-1:0] wr_ptr_nxt, rd_ptr_nxt;
    logic             is_full, is_empty;

    // Output process: decode state into acceptance and next values.
    always_comb begin
        cap       = bypass ? CNT_W'(1) : CNT_W'(DEPTH);
        is_full   = (state_q == OCC_FULL);
        is_empty  = (state_q == OCC_EMPTY);
        push_acc  = push_valid && !is_full && !flush;
        pop_acc   = pop_req && !is_empty && !flush;
        ufl_evt   = pop_req && is_empty && !flush;

        if (flush) begin
            count_nxt  = '0;
            wr_ptr_nxt = '0;
            rd_ptr_nxt = '0;
        end else begin
            count_nxt  = count + CNT_W'(push_acc) - CNT_W'(pop_acc);
            wr_ptr_nxt = push_acc ? ((wr_ptr == LAST_SLOT) ? '0 : wr_ptr + 1'b1) : wr_ptr;
            rd_ptr_nxt = pop_acc  ? ((rd_ptr == LAST_SLOT) ? '0 : rd_ptr + 1'b1) : rd_ptr;
        end
        full_nxt = (count_nxt >= cap);
    end

    // Next-state process with named transitions.
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            OCC_EMPTY: begin
                if (push_acc) state_nxt = (cap == CNT_W'(1)) ? OCC_FULL : OCC_PART;
            end
            OCC_PART: begin
                if (push_acc && !pop_acc && (count == cap - 1'b1))
                    state_nxt = OCC_FULL;
                else if (pop_acc && !push_acc && (count == CNT_W'(1)))
                    state_nxt = OCC_EMPTY;
            end
            OCC_FULL: begin
                if (pop_acc) state_nxt = (cap == CNT_W'(1)) ? OCC_EMPTY : OCC_PART;
            end
            default: state_nxt = OCC_EMPTY;
        endcase
        if (flush) state_nxt = OCC_EMPTY;
    end

    // State register process.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= OCC_EMPTY;
            count   <= '0;
            wr_ptr  <= '0;
            rd_ptr  <= '0;
        end else begin
            state_q <= state_nxt;
            count   <= count_nxt;
            wr_ptr  <= wr_ptr_nxt;
            rd_ptr  <= rd_ptr_nxt;
        end
    end

    assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

    assert_empty_state_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == OCC_EMPTY) == (count == '0));

    assert_full_push_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == OCC_FULL && push_valid && !pop_req && !flush) |=> $stable(count) && $stable(wr_ptr));

    assert_ptr_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_acc) |=> rd_ptr == (($past(rd_ptr) == LAST_SLOT) ? '0 : $past(rd_ptr) + 1'b1));

    assert_push_pop_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == OCC_PART && push_valid && pop_req && !flush) |=> $stable(count));

    assert_flush_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0) && (rd_ptr == '0) && (wr_ptr == '0));
endmodule

// File: rtl/spi_txq_flag.sv
module spi_txq_flag
    import spi_txq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic fill_clr,
    input  logic wr_done,
    input  logic full_nxt,
    input  logic ufl_evt,
    input  logic ufl_clr,
    output logic fill_flag,
    output logic underflow
);
    fill_state_t fst_q, fst_nxt;
    logic        ufl_nxt;

    always_comb begin
        fst_nxt = fst_q;
        unique case (fst_q)
            FL_REQ: begin
                if (flush)                    fst_nxt = FL_REQ;
                else if (fill_clr)            fst_nxt = FL_QUIET;
                else if (full_nxt && wr_done) fst_nxt = FL_QUIET;
            end
            FL_QUIET: begin
                if (flush || (!fill_clr && !full_nxt)) fst_nxt = FL_REQ;
            end
            default: fst_nxt = FL_REQ;
        endcase
        ufl_nxt = ufl_evt ? 1'b1 : (ufl_clr ? 1'b0 : underflow);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fst_q     <= FL_REQ;
            underflow <= 1'b0;
        end else begin
            fst_q     <= fst_nxt;
            underflow <= ufl_nxt;
        end
    end

    always_comb fill_flag = (fst_q == FL_REQ);

    assert_fill_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && !fill_clr && !full_nxt) |=> fill_flag);

    assert_fill_wclr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_clr && !flush) |=> !fill_flag);

    assert_flush_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> fill_flag);

    assert_underflow_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ufl_evt |=> underflow);
endmodule

// File: rtl/spi_txq.sv
module spi_txq #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bypass,
    input  logic              flush,
    input  logic              push_valid,
    input  logic              push_byte,
    input  logic [DATA_W-1:0] push_data,
    input  logic              wr_done,
    input  logic              fill_clr,
    input  logic              ufl_clr,
    input  logic              pop_req,
    output logic              pop_ack,
    output logic [DATA_W-1:0] pop_data,
    output logic [CNT_W-1:0]  count,
    output logic [PTR_W-1:0]  next_ptr,
    output logic              fill_flag,
    output logic              underflow,
    input  logic [PTR_W-1:0]  entry_idx,
    output logic [DATA_W-1:0] entry_data
);
    logic              push_acc, ufl_evt, full_nxt;
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [DATA_W-1:0] wr_word, peek_word;

    always_comb wr_word = push_byte ? DATA_W'(push_data[7:0]) : push_data;

    spi_txq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .bypass     (bypass),
        .flush      (flush),
        .push_valid (push_valid),
        .pop_req    (pop_req),
        .push_acc   (push_acc),
        .pop_acc    (pop_ack),
        .ufl_evt    (ufl_evt),
        .full_nxt   (full_nxt),
        .wr_ptr     (wr_ptr),
        .rd_ptr     (rd_ptr),
        .count      (count)
    );

    spi_txq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (push_acc),
        .wr_ptr    (wr_ptr),
        .wr_data   (wr_word),
        .rd_ptr    (rd_ptr),
        .rd_data   (pop_data),
        .peek_idx  (entry_idx),
        .peek_data (peek_word)
    );

    spi_txq_flag u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .fill_clr  (fill_clr),
        .wr_done   (wr_done),
        .full_nxt  (full_nxt),
        .ufl_evt   (ufl_evt),
        .ufl_clr   (ufl_clr),
        .fill_flag (fill_flag),
        .underflow (underflow)
    );

    always_comb begin
        next_ptr   = bypass ? '0 : rd_ptr;
        entry_data = bypass ? '0 : peek_word;
    end

    assert_bypass_cap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bypass && count != '0 && push_valid && !pop_req && !flush) |=> $stable(count));
endmodule

// File: tb/spi_txq_tb.sv
module spi_txq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bypass = 0, flush = 0, push_valid = 0, push_byte = 0;
    logic [15:0] push_data = '0;
    logic        wr_done = 0, fill_clr = 0, ufl_clr = 0, pop_req = 0;
    logic        pop_ack;
    logic [15:0] pop_data;
    logic [2:0]  count;
    logic [1:0]  next_ptr;
    logic        fill_flag, underflow;
    logic [1:0]  entry_idx = '0;
    logic [15:0] entry_data;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    spi_txq u_dut (
        .clk(clk), .rst_n(rst_n), .bypass(bypass), .flush(flush),
        .push_valid(push_valid), .push_byte(push_byte), .push_data(push_data),
        .wr_done(wr_done), .fill_clr(fill_clr), .ufl_clr(ufl_clr),
        .pop_req(pop_req), .pop_ack(pop_ack), .pop_data(pop_data),
        .count(count), .next_ptr(next_ptr), .fill_flag(fill_flag),
        .underflow(underflow), .entry_idx(entry_idx), .entry_data(entry_data)
    );

    typedef struct packed {
        logic        push;
        logic        pop;
        logic        byt;
        logic [15:0] data;
        logic [2:0]  cnt;
        logic [1:0]  ptr;
        logic [15:0] head;
        logic        fill;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 1'b0, 1'b0, 16'hA1A1, 3'd1, 2'd0, 16'hA1A1, 1'b1},
        '{1'b1, 1'b0, 1'b0, 16'hB2B2, 3'd2, 2'd0, 16'hA1A1, 1'b1},
        '{1'b1, 1'b1, 1'b0, 16'hC3C3, 3'd2, 2'd1, 16'hB2B2, 1'b1}, // R5
        '{1'b1, 1'b0, 1'b1, 16'h1234, 3'd3, 2'd1, 16'hB2B2, 1'b1}, // R6 byte
        '{1'b1, 1'b0, 1'b0, 16'hD4D4, 3'd4, 2'd1, 16'hB2B2, 1'b1}, // full
        '{1'b1, 1'b0, 1'b0, 16'hEEEE, 3'd4, 2'd1, 16'hB2B2, 1'b1}, // R3 drop
        '{1'b0, 1'b1, 1'b0, 16'h0000, 3'd3, 2'd2, 16'hC3C3, 1'b1},
        '{1'b0, 1'b1, 1'b0, 16'h0000, 3'd2, 2'd3, 16'h0034, 1'b1}, // R6 readout
        '{1'b0, 1'b1, 1'b0, 16'h0000, 3'd1, 2'd0, 16'hD4D4, 1'b1}, // R4 wrap
        '{1'b0, 1'b1, 1'b0, 16'h0000, 3'd0, 2'd1, 16'h0000, 1'b1}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic idle;
        push_valid = 0; push_byte = 0; pop_req = 0; flush = 0;
        wr_done = 0; fill_clr = 0; ufl_clr = 0;
    endtask

    task automatic push(input logic [15:0] d);
        push_valid = 1; push_data = d; tick; idle;
    endtask

    task automatic summary;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        summary;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        tick;
        // R1 reset state
        chk("R1 count", 32'(count), 0);
        chk("R1 next_ptr", 32'(next_ptr), 0);
        chk("R1 fill", 32'(fill_flag), 1);
        chk("R1 underflow", 32'(underflow), 0);

        for (int i = 0; i < NVEC; i++) begin
            push_valid = VECS[i].push; pop_req = VECS[i].pop;
            push_byte = VECS[i].byt; push_data = VECS[i].data;
            tick;
            idle;
            chk($sformatf("R2 R3 R5 count v%0d", i), 32'(count), 32'(VECS[i].cnt));
            chk($sformatf("R4 next_ptr v%0d", i), 32'(next_ptr), 32'(VECS[i].ptr));
            chk($sformatf("R7 fill v%0d", i), 32'(fill_flag), 32'(VECS[i].fill));
            if (VECS[i].cnt != 0)
                chk($sformatf("R2 R6 head v%0d", i), 32'(pop_data), 32'(VECS[i].head));
        end

        // R12: fill slots 1,2,3,0 and read them back
        push(16'h1111); push(16'h2222); push(16'h3333); push(16'h4444);
        entry_idx = 2'd0; #1; chk("R12 slot0", 32'(entry_data), 32'h4444);
        entry_idx = 2'd2; #1; chk("R12 slot2", 32'(entry_data), 32'h2222);

        // R7: full then wr_done clears request, pop sets it again
        chk("R7 full still req", 32'(fill_flag), 1);
        wr_done = 1; tick; idle;
        chk("R7 wr_done clear", 32'(fill_flag), 0);
        push(16'h5555);
        chk("R3 full push count", 32'(count), 4);
        chk("R3 full push flag", 32'(fill_flag), 0);
        pop_req = 1; #0.5; chk("R2 pop_ack", 32'(pop_ack), 1);
        chk("R2 pop word", 32'(pop_data), 32'h1111);
        tick; idle;
        chk("R7 set after pop", 32'(fill_flag), 1);

        // R9: flush with simultaneous push
        flush = 1; push_valid = 1; push_data = 16'h9999; tick; idle;
        chk("R9 count", 32'(count), 0);
        chk("R9 next_ptr", 32'(next_ptr), 0);
        chk("R9 fill", 32'(fill_flag), 1);

        // R8: write-1 clear, then re-set
        fill_clr = 1; tick; idle;
        chk("R8 cleared", 32'(fill_flag), 0);
        tick;
        chk("R8 re-set", 32'(fill_flag), 1);

        // R10: pop on empty
        pop_req = 1; #0.5; chk("R10 no ack", 32'(pop_ack), 0);
        tick; idle;
        chk("R10 underflow", 32'(underflow), 1);
        chk("R10 count", 32'(count), 0);
        ufl_clr = 1; pop_req = 1; tick; idle;
        chk("R10 set wins", 32'(underflow), 1);
        ufl_clr = 1; tick; idle;
        chk("R10 cleared", 32'(underflow), 0);

        // R11: bypass single-entry mode
        bypass = 1;
        push(16'hABCD);
        chk("R11 count1", 32'(count), 1);
        chk("R11 fill1", 32'(fill_flag), 1);
        push(16'h0F0F);
        chk("R11 drop", 32'(count), 1);
        entry_idx = 2'd1; #0.5;
        chk("R11 entry zero", 32'(entry_data), 0);
        chk("R11 next_ptr zero", 32'(next_ptr), 0);
        wr_done = 1; tick; idle;
        chk("R11 wr_done clear", 32'(fill_flag), 0);
        chk("R11 head", 32'(pop_data), 32'hABCD);
        pop_req = 1; tick; idle;
        chk("R11 empty", 32'(count), 0);
        chk("R11 fill reset", 32'(fill_flag), 1);
        bypass = 0;
        tick;
        summary;
    end
endmodule